// File: doc/BRIEF.md
# GPIO Signal Routing Matrix

This block is a configurable crossbar that sits between the chip's GPIO pads and the internal peripheral signals. Every peripheral input has a small configuration entry. The entry picks which pad feeds that input, or a fixed 0 or 1. It can invert the value, and it can take the signal from a dedicated direct (bypass) wire instead of through the matrix.

Every pad also has a configuration entry. It picks which peripheral output drives the pad, or selects the plain GPIO output register bit for that pad. It can invert the data. It also decides whether the pad's output enable comes from the GPIO enable register or from the chosen peripheral's own enable, and it can invert that enable.

Software writes the entries through a simple write port. The space bit chooses the input or the output table, the index picks the entry, and the data carries the fields. The routing itself is combinational. Only the configuration is held in flops, and it takes effect in the cycle after the write edge. The number of pads and peripheral signals are parameters. The pad count must be at most 48, so that pad codes and the constant codes do not overlap. The signal count must be between 2 and 256.

Top module: `gpio_xbar`

## Requirements
- R1: After reset, every input entry selects constant 0 with no inversion and no bypass, so all `periph_in` bits read 0. Every output entry selects code 256 with no inversions, so `pad_out` equals `gpio_out_reg` and `pad_oe` equals `gpio_oe_reg`.
- R2: An input entry holds a selector in `cfg_wdata[5:0]`. A selector value n with 0 <= n < NPAD routes `pad_in[n]` to that peripheral input.
- R3: Input selector 0x38 makes the peripheral input a constant 1. Input selector 0x30 makes it a constant 0.
- R4: Any other input selector at or above NPAD makes the peripheral input a 0, before inversion is applied.
- R5: Input entry bit 6 set inverts the peripheral input. The inversion applies after the source is chosen, and it also applies to constants and to the bypass value.
- R6: Input entry bit 7 set takes `bypass_in[i]` as the source for peripheral input i, regardless of the selector.
- R7: An output entry holds a selector in `cfg_wdata[8:0]`. A selector below NSIG routes `periph_out[sel]` to the pad. A selector of NSIG or more, other than 256, drives a 0 to the pad.
- R8: Output selector 256 routes `gpio_out_reg[p]` to pad p.
- R9: Output entry bit 9 set drives the pad with the complement of the routed data.
- R10: The pad enable is `gpio_oe_reg[p]` when the output selector is 256 or output entry bit 10 is set. Otherwise it is `periph_oe[sel]`, or 0 when the selector is not below NSIG.
- R11: Output entry bit 11 set inverts the pad enable.
- R12: A write (`cfg_we`=1, `cfg_dir`=0 for the input table, 1 for the output table, `cfg_idx` for the entry) lands at the clock edge and is visible from the next cycle on. It changes only the addressed entry, and an index beyond the table size changes nothing.
- R13: The data paths hold no register. A change on `pad_in`, `bypass_in`, `periph_out`, `periph_oe` or the GPIO registers shows up on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir | input | 1 | Table select: 0 input entries, 1 output entries |
| cfg_idx | input | 8 | Entry index |
| cfg_wdata | input | 12 | Entry contents |
| pad_in | input | NPAD | Values read from the pads |
| bypass_in | input | NSIG | Direct per-signal input wires |
| periph_in | output | NSIG | Routed inputs delivered to peripherals |
| periph_out | input | NSIG | Peripheral output data |
| periph_oe | input | NSIG | Peripheral output enables |
| gpio_out_reg | input | NPAD | Plain GPIO output register bits |
| gpio_oe_reg | input | NPAD | Plain GPIO enable register bits |
| pad_out | output | NPAD | Data driven toward the pads |
| pad_oe | output | NPAD | Output enable toward the pads |

## Verification
A configuration write is applied on the rising edge where `cfg_we` is high. Its effect on `periph_in`, `pad_out` and `pad_oe` is due from that edge on, so the bench drives each write at a falling edge, drops the strobe at the next falling edge, and samples after that. The data paths have zero latency. The bench therefore changes `pad_in`, `bypass_in`, the peripheral signals and the GPIO registers mid-cycle and samples one time step later, with no clock edge in between. The reset state is sampled only after the two-cycle synchronized release, and no writes are issued before that.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int IDX_W  = 8;
  localparam int CFG_W  = 12;
  localparam int ISEL_W = 6;
  localparam int OSEL_W = 9;

  localparam logic [ISEL_W-1:0] ISEL_ONE  = 6'h38;
  localparam logic [ISEL_W-1:0] ISEL_ZERO = 6'h30;
  localparam logic [OSEL_W-1:0] OSEL_GPIO = 9'd256;

  typedef struct packed {
    logic              byp;
    logic              inv;
    logic [ISEL_W-1:0] sel;
  } in_cfg_t;

  typedef struct packed {
    logic              oe_inv;
    logic              oe_reg;
    logic              inv;
    logic [OSEL_W-1:0] sel;
  } out_cfg_t;

  localparam in_cfg_t  IN_CFG_RST  = '{byp: 1'b0, inv: 1'b0, sel: ISEL_ZERO};
  localparam out_cfg_t OUT_CFG_RST = '{oe_inv: 1'b0, oe_reg: 1'b0, inv: 1'b0, sel: OSEL_GPIO};
endpackage

// File: rtl/gpx_cfg_bank.sv
module gpx_cfg_bank
  import gpx_pkg::*;
#(
  parameter int NPAD = 40,
  parameter int NSIG = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_dir,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [CFG_W-1:0]           cfg_wdata,
  output in_cfg_t  [NSIG-1:0]        in_cfg,
  output out_cfg_t [NPAD-1:0]        out_cfg
);
  localparam int IN_BITS = $bits(in_cfg_t);

  for (genvar i = 0; i < NSIG; i++) begin : g_in
    logic    hit;
    in_cfg_t nxt, cur;
    always_comb begin
      hit = cfg_we && !cfg_dir && (cfg_idx == IDX_W'(i));
      nxt = in_cfg_t'(cfg_wdata[IN_BITS-1:0]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur <= IN_CFG_RST;
      else if (hit) cur <= nxt;
    end
    assign in_cfg[i] = cur;
  end

  for (genvar p = 0; p < NPAD; p++) begin : g_out
    logic     hit;
    out_cfg_t nxt, cur;
    always_comb begin
      hit = cfg_we && cfg_dir && (cfg_idx == IDX_W'(p));
      nxt = out_cfg_t'(cfg_wdata);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur <= OUT_CFG_RST;
      else if (hit) cur <= nxt;
    end
    assign out_cfg[p] = cur;
  end
endmodule

// File: rtl/gpx_in_route.sv
module gpx_in_route
  import gpx_pkg::*;
#(
  parameter int NPAD = 40,
  parameter int NSIG = 16
) (
  input  in_cfg_t [NSIG-1:0] in_cfg,
  input  logic [NPAD-1:0]    pad_in,
  input  logic [NSIG-1:0]    bypass_in,
  output logic [NSIG-1:0]    periph_in
);
  localparam logic [ISEL_W-1:0] PAD_LIM = ISEL_W'(NPAD);

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    logic src, val;
    always_comb begin
      if (in_cfg[i].sel < PAD_LIM)        src = pad_in[in_cfg[i].sel];
      else if (in_cfg[i].sel == ISEL_ONE) src = 1'b1;
      else                                src = 1'b0;
      val = in_cfg[i].byp ? bypass_in[i] : src;
    end
    assign periph_in[i] = val ^ in_cfg[i].inv;
  end
endmodule

// File: rtl/gpx_out_route.sv
module gpx_out_route
  import gpx_pkg::*;
#(
  parameter int NPAD = 40,
  parameter int NSIG = 16
) (
  input  out_cfg_t [NPAD-1:0] out_cfg,
  input  logic [NSIG-1:0]     periph_out,
  input  logic [NSIG-1:0]     periph_oe,
  input  logic [NPAD-1:0]     gpio_out_reg,
  input  logic [NPAD-1:0]     gpio_oe_reg,
  output logic [NPAD-1:0]     pad_out,
  output logic [NPAD-1:0]     pad_oe
);
  localparam int SIDX_W = $clog2(NSIG);
  localparam logic [OSEL_W-1:0] SIG_LIM = OSEL_W'(NSIG);

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic              gpio_mode, in_rng, oe_from_reg;
    logic              pdat, pena, dat, ena;
    logic [SIDX_W-1:0] sidx;
    always_comb begin
      gpio_mode   = (out_cfg[p].sel == OSEL_GPIO);
      in_rng      = (out_cfg[p].sel < SIG_LIM);
      oe_from_reg = gpio_mode || out_cfg[p].oe_reg;
      sidx        = out_cfg[p].sel[SIDX_W-1:0];
      pdat        = in_rng ? periph_out[sidx] : 1'b0;
      pena        = in_rng ? periph_oe[sidx]  : 1'b0;
      dat         = gpio_mode   ? gpio_out_reg[p] : pdat;
      ena         = oe_from_reg ? gpio_oe_reg[p]  : pena;
    end
    assign pad_out[p] = dat ^ out_cfg[p].inv;
    assign pad_oe[p]  = ena ^ out_cfg[p].oe_inv;
  end
endmodule

// File: rtl/gpio_xbar.sv
module gpio_xbar
  import gpx_pkg::*;
#(
  parameter int NPAD = 40,
  parameter int NSIG = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_dir,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [NPAD-1:0]      pad_in,
  input  logic [NSIG-1:0]      bypass_in,
  output logic [NSIG-1:0]      periph_in,
  input  logic [NSIG-1:0]      periph_out,
  input  logic [NSIG-1:0]      periph_oe,
  input  logic [NPAD-1:0]      gpio_out_reg,
  input  logic [NPAD-1:0]      gpio_oe_reg,
  output logic [NPAD-1:0]      pad_out,
  output logic [NPAD-1:0]      pad_oe
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  in_cfg_t  [NSIG-1:0] in_cfg;
  out_cfg_t [NPAD-1:0] out_cfg;

  gpx_cfg_bank #(.NPAD(NPAD), .NSIG(NSIG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_dir   (cfg_dir),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .in_cfg    (in_cfg),
    .out_cfg   (out_cfg)
  );

  gpx_in_route #(.NPAD(NPAD), .NSIG(NSIG)) u_in (
    .in_cfg    (in_cfg),
    .pad_in    (pad_in),
    .bypass_in (bypass_in),
    .periph_in (periph_in)
  );

  gpx_out_route #(.NPAD(NPAD), .NSIG(NSIG)) u_out (
    .out_cfg      (out_cfg),
    .periph_out   (periph_out),
    .periph_oe    (periph_oe),
    .gpio_out_reg (gpio_out_reg),
    .gpio_oe_reg  (gpio_oe_reg),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe)
  );
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
  parameter int NPAD = 40,
  parameter int NSIG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_dir,
  input logic [7:0]      cfg_idx,
  input logic [11:0]     cfg_wdata,
  input logic [NSIG-1:0] bypass_in,
  input logic [NSIG-1:0] periph_in,
  input logic [NPAD-1:0] gpio_out_reg,
  input logic [NPAD-1:0] gpio_oe_reg,
  input logic [NPAD-1:0] pad_out,
  input logic [NPAD-1:0] pad_oe
);
  localparam int SW = $clog2(NSIG);
  localparam int PW = $clog2(NPAD);

  logic in_wr, out_wr;
  assign in_wr  = cfg_we && !cfg_dir && (int'(cfg_idx) < NSIG);
  assign out_wr = cfg_we &&  cfg_dir && (int'(cfg_idx) < NPAD);

  // R3
  const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && cfg_wdata[7:0] == 8'h38) |=> periph_in[$past(cfg_idx[SW-1:0])] == 1'b1);

  // R3
  const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && cfg_wdata[7:0] == 8'h30) |=> periph_in[$past(cfg_idx[SW-1:0])] == 1'b0);

  // R4
  undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && cfg_wdata[7:0] == 8'h3F) |=> periph_in[$past(cfg_idx[SW-1:0])] == 1'b0);

  // R6
  bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && cfg_wdata[7:6] == 2'b10) |=>
      periph_in[$past(cfg_idx[SW-1:0])] == bypass_in[$past(cfg_idx[SW-1:0])]);

  // R8
  gpio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && cfg_wdata == 12'h100) |=>
      (pad_out[$past(cfg_idx[PW-1:0])] == gpio_out_reg[$past(cfg_idx[PW-1:0])]) &&
      (pad_oe[$past(cfg_idx[PW-1:0])]  == gpio_oe_reg[$past(cfg_idx[PW-1:0])]));

  // R7
  out_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && cfg_wdata == 12'h1FF) |=>
      !pad_out[$past(cfg_idx[PW-1:0])] && !pad_oe[$past(cfg_idx[PW-1:0])]);
endmodule

bind gpio_xbar gpx_chk #(.NPAD(NPAD), .NSIG(NSIG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cfg_we       (cfg_we),
  .cfg_dir      (cfg_dir),
  .cfg_idx      (cfg_idx),
  .cfg_wdata    (cfg_wdata),
  .bypass_in    (bypass_in),
  .periph_in    (periph_in),
  .gpio_out_reg (gpio_out_reg),
  .gpio_oe_reg  (gpio_oe_reg),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe)
);

// File: tb/sim_gpio_xbar.sv
`timescale 1ns/1ps
module sim_gpio_xbar;
  localparam int NPAD = 40;
  localparam int NSIG = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we, cfg_dir;
  logic [7:0]      cfg_idx;
  logic [11:0]     cfg_wdata;
  logic [NPAD-1:0] pad_in, gpio_out_reg, gpio_oe_reg, pad_out, pad_oe;
  logic [NSIG-1:0] bypass_in, periph_in, periph_out, periph_oe;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  gpio_xbar #(.NPAD(NPAD), .NSIG(NSIG)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .pad_in(pad_in),
    .bypass_in(bypass_in), .periph_in(periph_in), .periph_out(periph_out),
    .periph_oe(periph_oe), .gpio_out_reg(gpio_out_reg),
    .gpio_oe_reg(gpio_oe_reg), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(logic dir, int idx, logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = dir; cfg_idx = idx[7:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic exp_in(logic [5:0] c, logic inv, logic byp,
                                  logic [NPAD-1:0] pads, logic bv);
    logic v;
    if (byp)               v = bv;
    else if (int'(c) < NPAD) v = pads[c];
    else if (c == 6'h38)   v = 1'b1;
    else                   v = 1'b0;
    return v ^ inv;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_dir = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    pad_in = '0; bypass_in = '0; periph_out = '0; periph_oe = '0;
    gpio_out_reg = '0; gpio_oe_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state with two stimulus patterns
    for (int k = 0; k < 2; k++) begin
      logic [63:0] r = rnd64();
      pad_in = r[NPAD-1:0]; bypass_in = r[NSIG-1:0];
      periph_out = ~r[NSIG-1:0]; periph_oe = r[NSIG-1:0];
      gpio_out_reg = r[NPAD-1:0]; gpio_oe_reg = ~r[NPAD-1:0];
      #1;
      chk("R1", "periph_in", 64'(periph_in), 64'(0));
      chk("R1", "pad_out", 64'(pad_out), 64'(gpio_out_reg));
      chk("R1", "pad_oe", 64'(pad_oe), 64'(gpio_oe_reg));
    end

    // R2 R3 R4 R5: every selector code with and without inversion
    for (int i = 0; i < NSIG; i++) begin
      for (int c = 0; c < 64; c++) begin
        for (int inv = 0; inv < 2; inv++) begin
          string tag;
          wr(1'b0, i, {4'b0, 1'b0, 1'(inv), 6'(c)});
          if (c < NPAD)                    tag = inv ? "R2/R5" : "R2";
          else if (c == 'h38 || c == 'h30) tag = inv ? "R3/R5" : "R3";
          else                             tag = inv ? "R4/R5" : "R4";
          for (int k = 0; k < 2; k++) begin
            logic [63:0] r = rnd64();
            pad_in = k ? ~r[NPAD-1:0] : r[NPAD-1:0];
            bypass_in = r[NSIG-1:0];
            #1;
            chk(tag, $sformatf("sig%0d code%0h", i, c), 64'(periph_in[i]),
                64'(exp_in(6'(c), 1'(inv), 1'b0, pad_in, bypass_in[i])));
          end
        end
      end
    end

    // R6: bypass wins over any selector, inversion still applies (R5)
    for (int i = 0; i < NSIG; i++) begin
      for (int inv = 0; inv < 2; inv++) begin
        logic [5:0] c = 6'($urandom_range(0, 63));
        wr(1'b0, i, {4'b0, 1'b1, 1'(inv), c});
        for (int k = 0; k < 2; k++) begin
          logic [63:0] r = rnd64();
          pad_in = r[NPAD-1:0];
          bypass_in = k ? ~r[63:64-NSIG] : r[63:64-NSIG];
          #1;
          chk("R6", $sformatf("bypass sig%0d", i), 64'(periph_in[i]),
              64'(exp_in(c, 1'(inv), 1'b1, pad_in, bypass_in[i])));
        end
      end
    end

    // R13: mid-cycle input change shows up without a clock edge
    wr(1'b0, 0, {4'b0, 2'b00, 6'd5});
    @(posedge clk); #2;
    pad_in[5] = 1'b1; #1;
    chk("R13", "same-cycle rise", 64'(periph_in[0]), 64'(1));
    pad_in[5] = 1'b0; #1;
    chk("R13", "same-cycle fall", 64'(periph_in[0]), 64'(0));

    // R12: a write touches only the addressed entry, out-of-range ignored
    for (int i = 0; i < NSIG; i++) wr(1'b0, i, 12'h038);
    wr(1'b0, 3, 12'h030);
    wr(1'b0, NSIG, 12'h030);
    wr(1'b1, 3, 12'h000);
    #1;
    chk("R12", "isolation inputs", 64'(periph_in), 64'({NSIG{1'b1}} & ~(NSIG'(1) << 3)));

    // R7 R8 R9 R10 R11: output selector sweep over all flag combinations
    for (int p = 0; p < NPAD; p++) begin
      int sels [$];
      sels = {};
      for (int s = 0; s <= NSIG; s++) sels.push_back(s);
      sels.push_back(255); sels.push_back(256); sels.push_back(257); sels.push_back(511);
      foreach (sels[j]) begin
        for (int f = 0; f < 8; f++) begin
          logic [8:0] s = 9'(sels[j]);
          logic inv = f[0], oer = f[1], oei = f[2];
          wr(1'b1, p, {oei, oer, inv, s});
          for (int k = 0; k < 2; k++) begin
            logic [63:0] r = rnd64();
            logic ed, ee;
            logic [63:0] q = rnd64();
            periph_out   = k ? ~r[NSIG-1:0] : r[NSIG-1:0];
            periph_oe    = q[NSIG-1:0];
            gpio_out_reg = k ? ~q[63:64-NPAD] : q[63:64-NPAD];
            gpio_oe_reg  = r[63:64-NPAD];
            #1;
            if (s == 9'd256)      ed = gpio_out_reg[p];
            else if (s < NSIG)    ed = periph_out[s[3:0]];
            else                  ed = 1'b0;
            if (s == 9'd256 || oer) ee = gpio_oe_reg[p];
            else if (s < NSIG)      ee = periph_oe[s[3:0]];
            else                    ee = 1'b0;
            chk(s == 9'd256 ? (inv ? "R8/R9" : "R8") : (inv ? "R7/R9" : "R7"),
                $sformatf("pad%0d sel%0d out", p, s), 64'(pad_out[p]), 64'(ed ^ inv));
            chk(oei ? "R10/R11" : "R10",
                $sformatf("pad%0d sel%0d oe", p, s), 64'(pad_oe[p]), 64'(ee ^ oei));
          end
        end
      end
    end

    // R12: out-of-range output index changes no pad
    for (int p = 0; p < NPAD; p++) wr(1'b1, p, 12'h100);
    wr(1'b1, NPAD, 12'hE00);
    gpio_out_reg = rnd64()[NPAD-1:0]; gpio_oe_reg = rnd64()[NPAD-1:0];
    #1;
    chk("R12", "ignored out index data", 64'(pad_out), 64'(gpio_out_reg));
    chk("R12", "ignored out index oe", 64'(pad_oe), 64'(gpio_oe_reg));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule